// File: doc/BRIEF.md
# Stop-Clock Power Sequencer

This block puts a processor core into a low-power grant state when an external stop request arrives, and brings it back out again. The request is an asynchronous active-low pin. The block first passes it through a short synchronizer. It then walks the core through a fixed quiesce order: halt at an instruction boundary, let any cache flush finish, stop prefetch, and drain the pipelines and write buffers. It then announces the stop with one special bus cycle that has a fixed encoding. Only after the system acknowledges that cycle does it drop the core clock enable.

The request must be released before the core runs again. When the synchronized request deasserts, the clock enable rises and every stop strobe to the core drops on the same edge, so execution carries on from the instruction after the one it stopped at. After the acknowledge, the request has to stay released for a minimum number of clocks. A request that comes back sooner is flagged and is held off until that spacing has passed. The sequence never starts while the bus is granted to another master, or while a higher-priority interrupt is pending.

Top module: `stopclk_seq`

## Requirements
- R1: `stop_req_n` (active low) passes through two flip-flops. If it is low at clock edge k with everything else allowing a start, `core_stop` is 0 after edge k+1 and 1 after edge k+2.
- R2: A start is withheld for as long as `hold_ack` or `hi_pri_irq` is 1. The sequence starts once both are 0 and the request is still active.
- R3: `core_stop` is asserted first. `prefetch_stop` is asserted only after `at_boundary` and then `flush_done` have been seen. `drain_req` is asserted only after `prefetch_idle` has been seen.
- R4: The grant bus cycle (`cyc_valid`=1) starts only after `drain_empty` is 1 while `hold_ack` is 0. It carries `cyc_mio`=0, `cyc_dc`=0, `cyc_wr`=1, `cyc_addr`=32'h0000_0010 and `cyc_be_n`=4'b1011. No other bus cycle is ever issued, so there is no interrupt acknowledge and no table read.
- R5: The grant bus cycle stays valid until `bus_rdy` or `bus_brdy` is 1 at a clock edge. Either one acknowledges the cycle.
- R6: `core_clk_en` is a register. It goes to 0 on the edge that takes the acknowledge, and at no other time.
- R7: In the grant state, a synchronized deassertion of the request sets `core_clk_en` to 1 and clears `core_stop`, `prefetch_stop` and `drain_req` on the same edge.
- R8: If the request is active again in the idle state fewer than GAP_CLKS (5) clocks after the acknowledge edge, `spacing_err` is 1 and no sequence starts. Once the gap has passed, the error clears and the sequence starts.
- R9: During reset, `core_clk_en`=1 and `core_stop`, `prefetch_stop`, `drain_req`, `cyc_valid` and `spacing_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| hi_pri_irq | input | 1 | Higher-priority interrupt pending; blocks a start |
| hold_ack | input | 1 | Bus granted to another master |
| at_boundary | input | 1 | Core has reached an instruction boundary |
| flush_done | input | 1 | No cache flush in progress |
| prefetch_idle | input | 1 | Prefetch unit stopped |
| drain_empty | input | 1 | Pipelines and write buffers empty |
| bus_rdy | input | 1 | Normal ready for the bus cycle |
| bus_brdy | input | 1 | Burst ready for the bus cycle |
| core_stop | output | 1 | Ask the core to halt at the next boundary |
| prefetch_stop | output | 1 | Ask prefetch to stop |
| drain_req | output | 1 | Ask the core to drain pipelines and write buffers |
| cyc_valid | output | 1 | Grant bus cycle active |
| cyc_mio | output | 1 | Memory/IO select of the cycle |
| cyc_dc | output | 1 | Data/control select of the cycle |
| cyc_wr | output | 1 | Write/read select of the cycle |
| cyc_addr | output | 32 | Address of the cycle |
| cyc_be_n | output | 4 | Active-low byte enables of the cycle |
| core_clk_en | output | 1 | Registered clock enable for the core |
| spacing_err | output | 1 | Request came back too soon after the acknowledge |

## Verification
The bench uses the default parameters: a two-stage synchronizer and a GAP_CLKS value of 5. The request-to-strobe delay is therefore three edges, and a release followed by an immediate reassertion falls inside the spacing window. With these values one directed pass can show the error cycle and the start one edge later. The table of vectors moves one status flag per row, so each step of the quiesce order shows up alone, including a drain held off by `hold_ack` and an acknowledge by burst-ready.

// File: rtl/stopclk_seq.sv
module stopclk_seq #(
  parameter int          SYNC_STAGES = 2,
  parameter int          GAP_CLKS    = 5,
  parameter logic [31:0] GRANT_ADDR  = 32'h0000_0010,
  parameter logic [3:0]  GRANT_BE_N  = 4'b1011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_req_n,
  input  logic        hi_pri_irq,
  input  logic        hold_ack,
  input  logic        at_boundary,
  input  logic        flush_done,
  input  logic        prefetch_idle,
  input  logic        drain_empty,
  input  logic        bus_rdy,
  input  logic        bus_brdy,
  output logic        core_stop,
  output logic        prefetch_stop,
  output logic        drain_req,
  output logic        cyc_valid,
  output logic        cyc_mio,
  output logic        cyc_dc,
  output logic        cyc_wr,
  output logic [31:0] cyc_addr,
  output logic [3:0]  cyc_be_n,
  output logic        core_clk_en,
  output logic        spacing_err
);

  localparam int GW = $clog2(GAP_CLKS + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(GAP_CLKS);

  typedef enum logic [2:0] {
    S_IDLE, S_BOUND, S_FLUSH, S_PREF, S_DRAIN, S_CYCLE, S_GRANT
  } st_t;

  st_t state, state_nx;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [GW-1:0] gap_cnt;
  logic req_act, ack, gap_ok, start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], stop_req_n};

  assign req_act = ~sync_q[SYNC_STAGES-1];
  assign ack     = cyc_valid & (bus_rdy | bus_brdy);
  assign gap_ok  = (gap_cnt == GAP_FULL);
  assign start   = req_act & ~hold_ack & ~hi_pri_irq & gap_ok;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (start)                     state_nx = S_BOUND;
      S_BOUND: if (at_boundary)               state_nx = S_FLUSH;
      S_FLUSH: if (flush_done)                state_nx = S_PREF;
      S_PREF:  if (prefetch_idle)             state_nx = S_DRAIN;
      S_DRAIN: if (drain_empty && !hold_ack)  state_nx = S_CYCLE;
      S_CYCLE: if (ack)                       state_nx = S_GRANT;
      S_GRANT: if (!req_act)                  state_nx = S_IDLE;
      default:                                state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      core_clk_en <= 1'b1;
      spacing_err <= 1'b0;
      gap_cnt     <= GAP_FULL;
    end else begin
      state       <= state_nx;
      core_clk_en <= (state_nx != S_GRANT);
      spacing_err <= (state == S_IDLE) && req_act && !gap_ok;
      if (ack)          gap_cnt <= '0;
      else if (!gap_ok) gap_cnt <= gap_cnt + 1'b1;
    end

  assign core_stop     = (state != S_IDLE);
  assign prefetch_stop = (state == S_PREF) || (state == S_DRAIN) ||
                         (state == S_CYCLE) || (state == S_GRANT);
  assign drain_req     = (state == S_DRAIN) || (state == S_CYCLE) ||
                         (state == S_GRANT);
  assign cyc_valid     = (state == S_CYCLE);
  assign cyc_mio       = 1'b0;
  assign cyc_dc        = 1'b0;
  assign cyc_wr        = 1'b1;
  assign cyc_addr      = GRANT_ADDR;
  assign cyc_be_n      = GRANT_BE_N;

  a_r2_start_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stop) |-> $past(req_act && !hold_ack && !hi_pri_irq));

  a_r3_flush_before_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prefetch_stop) |-> $past(flush_done));

  a_r4_drained_before_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_valid) |-> $past(drain_empty && !hold_ack));

  a_r5_cycle_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !bus_rdy && !bus_brdy) |=> cyc_valid);

  a_r6_gate_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(cyc_valid && (bus_rdy || bus_brdy)));

  a_r7_resume_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (!core_stop && !prefetch_stop && !drain_req));

  a_r8_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_err |-> (!core_stop && core_clk_en));

endmodule

// File: tb/stopclk_seq_tb_top.sv
module stopclk_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic hi_pri_irq = 0, hold_ack = 0, at_boundary = 0, flush_done = 0;
  logic prefetch_idle = 0, drain_empty = 0, bus_rdy = 0, bus_brdy = 0;
  logic core_stop, prefetch_stop, drain_req, cyc_valid, cyc_mio, cyc_dc, cyc_wr;
  logic [31:0] cyc_addr;
  logic [3:0] cyc_be_n;
  logic core_clk_en, spacing_err;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stopclk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .hi_pri_irq(hi_pri_irq),
    .hold_ack(hold_ack), .at_boundary(at_boundary), .flush_done(flush_done),
    .prefetch_idle(prefetch_idle), .drain_empty(drain_empty), .bus_rdy(bus_rdy),
    .bus_brdy(bus_brdy), .core_stop(core_stop), .prefetch_stop(prefetch_stop),
    .drain_req(drain_req), .cyc_valid(cyc_valid), .cyc_mio(cyc_mio), .cyc_dc(cyc_dc),
    .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cyc_be_n(cyc_be_n),
    .core_clk_en(core_clk_en), .spacing_err(spacing_err)
  );

  // inputs {req,hold,hipri,bound,flush,pref,drain,rdy,brdy}
  // expect {core_stop,prefetch_stop,drain_req,cyc_valid,core_clk_en,spacing_err}
  localparam logic [14:0] VEC [14] = '{
    15'b000000000_000010,  // R9 idle
    15'b110000000_000010,  // R2 hold blocks
    15'b101000000_000010,  // R2 irq blocks
    15'b100000000_100010,  // R1 start
    15'b100100000_100010,  // R3 flush pending
    15'b100110000_110010,  // R3 prefetch stop
    15'b100111000_111010,  // R3 drain request
    15'b110111100_111010,  // R4 hold stalls drain
    15'b100111100_111110,  // R4 grant cycle
    15'b100111100_111110,  // R5 waits for ready
    15'b100111101_111000,  // R6 burst ack gates clock
    15'b100111100_111000,  // R6 stays gated
    15'b000111100_000010,  // R7 resume
    15'b000000000_000010   // R7 idle again
  };
  localparam int VREQ [14] = '{9, 2, 2, 1, 3, 3, 3, 4, 4, 5, 6, 6, 7, 7};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(2);
    chk("R9 reset clk_en", core_clk_en, 1);
    chk("R9 reset strobes", {core_stop, prefetch_stop, drain_req, cyc_valid, spacing_err}, 0);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < 14; i++) begin
      {stop_req_n, hold_ack, hi_pri_irq, at_boundary, flush_done,
       prefetch_idle, drain_empty, bus_rdy, bus_brdy} = VEC[i][14:6] ^ 9'b100000000;
      step(4);
      checks++;
      if ({core_stop, prefetch_stop, drain_req, cyc_valid, core_clk_en, spacing_err} !== VEC[i][5:0]) begin
        errors++;
        $display("FAIL R%0d row %0d: got %b expected %b", VREQ[i], i,
                 {core_stop, prefetch_stop, drain_req, cyc_valid, core_clk_en, spacing_err}, VEC[i][5:0]);
      end
    end

    stop_req_n = 1'b0;
    step(2);
    chk("R1 not yet", core_stop, 0);
    step(1);
    chk("R1 third edge", core_stop, 1);
    {at_boundary, flush_done, prefetch_idle, drain_empty} = 4'b1111;
    step(4);
    chk("R4 cycle valid", cyc_valid, 1);
    chk("R4 encoding", {cyc_mio, cyc_dc, cyc_wr, cyc_be_n}, 7'b0011011);
    chk("R4 address", cyc_addr, 32'h0000_0010);
    chk("R6 clk_en before ack", core_clk_en, 1);
    bus_rdy = 1'b1;
    step(1);
    chk("R5 rdy ack", cyc_valid, 0);
    chk("R6 gated on ack", core_clk_en, 0);
    bus_rdy = 1'b0;
    {at_boundary, flush_done, prefetch_idle, drain_empty} = 4'b0000;
    stop_req_n = 1'b1;
    step(2);
    chk("R7 still gated", core_clk_en, 0);
    stop_req_n = 1'b0;
    step(1);
    chk("R7 clk_en back", core_clk_en, 1);
    chk("R7 strobes cleared", {core_stop, prefetch_stop, drain_req}, 0);
    step(2);
    chk("R8 spacing error", spacing_err, 1);
    chk("R8 start withheld", core_stop, 0);
    step(1);
    chk("R8 error clears", spacing_err, 0);
    chk("R8 start after gap", core_stop, 1);

    rst_n = 1'b0;
    stop_req_n = 1'b1;
    step(1);
    chk("R9 mid-run reset clk_en", core_clk_en, 1);
    chk("R9 mid-run reset strobes", {core_stop, prefetch_stop, drain_req, cyc_valid, spacing_err}, 0);
    finish_run();
  end
endmodule